// File: doc/BRIEF.md
# Paired Operand Register File with Guard Extension

This block is the operand storage of a DSP datapath. It holds sixteen 16-bit registers. Any two neighbouring registers, an even one and the odd one above it, also act as a single 32-bit operand, with the odd register as the upper half. Each of the eight pairs has its own 8-bit guard register, so a pair can be viewed as a 40-bit accumulator value whose top byte is the guard.

The block has one write port and two independent read ports. Each port carries a 2-bit size code: 0 selects one 16-bit register, 1 selects a 32-bit pair, 2 selects the 40-bit guarded pair, and 3 is reserved and behaves exactly like 0. A pair is chosen by bits 3..1 of the 4-bit register index, so an odd index reaches the same pair as the even index below it. Reads are combinational. A read in the same cycle as a write sees the value being written wherever the two overlap, and the stored value everywhere else.

There is no state machine. Storage is a bank of flops with an asynchronous active-low clear, fed by a write decoder and read by two instances of one read multiplexer.

Top module: `opf_regfile`

## Requirements
- R1: While rst_n is low, every register and every guard reads as zero on both read ports, whatever the size code.
- R2: A 16-bit write (size 0) to index i stores wr_data[15:0] in register i only. The other fifteen registers and all guards keep their values, and wr_data[39:16] is ignored.
- R3: A 32-bit write (size 1) stores wr_data[15:0] in the even register and wr_data[31:16] in the odd register of the pair. It sets that pair's guard to eight copies of wr_data[31] and ignores wr_data[39:32].
- R4: A 40-bit write (size 2) stores the pair as in R3 and sets the pair's guard to wr_data[39:32].
- R5: Pair accesses use wr_idx[3:1] or rd_idx[3:1] as the pair number, so indices 2p and 2p+1 address the same pair p.
- R6: A 16-bit read returns the register zero-extended to 40 bits. A 32-bit read returns {8'h00, odd, even} and ignores the guard. A 40-bit read returns {guard, odd, even}.
- R7: A read in the same cycle as a write to an overlapping location returns the newly written bits for every overlapping register or guard and the stored bits for the rest.
- R8: With wr_en low, nothing is stored and no read is bypassed, whatever wr_size, wr_idx and wr_data carry.
- R9: Size code 3 behaves as size code 0 on the write port and on both read ports.
- R10: The two read ports work independently: each returns its own selection in the same cycle, whatever the other port selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low clear of all registers and guards |
| wr_en | input | 1 | Write enable |
| wr_size | input | 2 | Write size code (0: 16-bit, 1: 32-bit pair, 2: 40-bit guarded, 3: as 0) |
| wr_idx | input | 4 | Write register index (bits 3..1 give the pair) |
| wr_data | input | 40 | Write data, right-aligned |
| rd_size_a | input | 2 | Read port A size code |
| rd_idx_a | input | 4 | Read port A register index |
| rd_data_a | output | 40 | Read port A data, zero-extended for narrow sizes |
| rd_size_b | input | 2 | Read port B size code |
| rd_idx_b | input | 4 | Read port B register index |
| rd_data_b | output | 40 | Read port B data, zero-extended for narrow sizes |

## Verification
The bench targets the guard cases. A 32-bit write with bit 31 set must fill the guard with ones, and one with bit 31 clear must clear a guard that was non-zero before. A design that kept the old guard, or took it from wr_data[39:32], would return the wrong top byte on the next 40-bit read. A later 16-bit write into the same pair must leave the guard alone, and a design that cleared the guard there would lose the top byte. The bench also reads an odd index as a pair, reads in the cycle of a partly overlapping write so that new and stored halves meet in one word, drives a full 40-bit write with wr_en low to expose a bypass that ignores the enable, and uses the reserved size code, which a wrong decoder would treat as a pair write that changes the neighbouring register.

// File: rtl/opf_pkg.sv
package opf_pkg;

    typedef enum logic [1:0] {
        SZ_HALF = 2'd0,
        SZ_PAIR = 2'd1,
        SZ_WIDE = 2'd2,
        SZ_RSVD = 2'd3
    } opf_size_e;

endpackage

// File: rtl/opf_wdec.sv
module opf_wdec
    import opf_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int NREG  = 16,
    parameter int GRD_W = 8,
    localparam int IW    = $clog2(NREG),
    localparam int NPAIR = NREG / 2,
    localparam int FW    = 2 * REG_W + GRD_W
) (
    input  logic             wr_en,
    input  logic [1:0]       wr_size,
    input  logic [IW-1:0]    wr_idx,
    input  logic [FW-1:0]    wr_data,
    output logic             reg_we [NREG],
    output logic [REG_W-1:0] reg_wd [NREG],
    output logic             grd_we [NPAIR],
    output logic [GRD_W-1:0] grd_wd [NPAIR]
);

    opf_size_e size_s;
    assign size_s = opf_size_e'(wr_size);

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        localparam int PI = i / 2;
        localparam bit HI = (i % 2) == 1;
        always_comb begin
            unique case (size_s)
                SZ_PAIR, SZ_WIDE: begin
                    reg_we[i] = wr_en && (wr_idx[IW-1:1] == IW'(PI) >> 0 ? 1'b1 : 1'b0) && (32'(wr_idx[IW-1:1]) == PI);
                    reg_wd[i] = HI ? wr_data[2*REG_W-1:REG_W] : wr_data[REG_W-1:0];
                end
                default: begin
                    reg_we[i] = wr_en && (32'(wr_idx) == i);
                    reg_wd[i] = wr_data[REG_W-1:0];
                end
            endcase
        end
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_grd
        always_comb begin
            unique case (size_s)
                SZ_PAIR: begin
                    grd_we[p] = wr_en && (32'(wr_idx[IW-1:1]) == p);
                    grd_wd[p] = {GRD_W{wr_data[2*REG_W-1]}};
                end
                SZ_WIDE: begin
                    grd_we[p] = wr_en && (32'(wr_idx[IW-1:1]) == p);
                    grd_wd[p] = wr_data[FW-1:2*REG_W];
                end
                default: begin
                    grd_we[p] = 1'b0;
                    grd_wd[p] = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/opf_store.sv
module opf_store #(
    parameter int REG_W = 16,
    parameter int NREG  = 16,
    parameter int GRD_W = 8,
    localparam int NPAIR = NREG / 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we   [NREG],
    input  logic [REG_W-1:0] reg_wd   [NREG],
    input  logic             grd_we   [NPAIR],
    input  logic [GRD_W-1:0] grd_wd   [NPAIR],
    output logic [REG_W-1:0] reg_view [NREG],
    output logic [GRD_W-1:0] grd_view [NPAIR]
);

    logic [REG_W-1:0] reg_q [NREG];
    logic [GRD_W-1:0] grd_q [NPAIR];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                reg_q[i] <= '0;
            end else if (reg_we[i]) begin
                reg_q[i] <= reg_wd[i];
            end
        end
        assign reg_view[i] = !rst_n ? '0 : (reg_we[i] ? reg_wd[i] : reg_q[i]);
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_grd
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                grd_q[p] <= '0;
            end else if (grd_we[p]) begin
                grd_q[p] <= grd_wd[p];
            end
        end
        assign grd_view[p] = !rst_n ? '0 : (grd_we[p] ? grd_wd[p] : grd_q[p]);
    end

endmodule

// File: rtl/opf_rport.sv
module opf_rport
    import opf_pkg::*;
#(
    parameter int REG_W = 16,
    parameter int NREG  = 16,
    parameter int GRD_W = 8,
    localparam int IW    = $clog2(NREG),
    localparam int NPAIR = NREG / 2,
    localparam int FW    = 2 * REG_W + GRD_W
) (
    input  logic [1:0]       rd_size,
    input  logic [IW-1:0]    rd_idx,
    input  logic [REG_W-1:0] reg_view [NREG],
    input  logic [GRD_W-1:0] grd_view [NPAIR],
    output logic [FW-1:0]    rd_data
);

    opf_size_e        size_s;
    logic [IW-2:0]    pidx;
    logic [REG_W-1:0] lo_w;
    logic [REG_W-1:0] hi_w;

    assign size_s = opf_size_e'(rd_size);
    assign pidx   = rd_idx[IW-1:1];
    assign lo_w   = reg_view[{pidx, 1'b0}];
    assign hi_w   = reg_view[{pidx, 1'b1}];

    always_comb begin
        unique case (size_s)
            SZ_PAIR: rd_data = {{GRD_W{1'b0}}, hi_w, lo_w};
            SZ_WIDE: rd_data = {grd_view[pidx], hi_w, lo_w};
            default: rd_data = {{(FW-REG_W){1'b0}}, reg_view[rd_idx]};
        endcase
    end

endmodule

// File: rtl/opf_regfile.sv
module opf_regfile #(
    parameter int REG_W = 16,
    parameter int NREG  = 16,
    parameter int GRD_W = 8,
    localparam int IW    = $clog2(NREG),
    localparam int NPAIR = NREG / 2,
    localparam int FW    = 2 * REG_W + GRD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_size,
    input  logic [IW-1:0] wr_idx,
    input  logic [FW-1:0] wr_data,
    input  logic [1:0]    rd_size_a,
    input  logic [IW-1:0] rd_idx_a,
    output logic [FW-1:0] rd_data_a,
    input  logic [1:0]    rd_size_b,
    input  logic [IW-1:0] rd_idx_b,
    output logic [FW-1:0] rd_data_b
);

    localparam int NRP = 2;

    logic             reg_we   [NREG];
    logic [REG_W-1:0] reg_wd   [NREG];
    logic             grd_we   [NPAIR];
    logic [GRD_W-1:0] grd_wd   [NPAIR];
    logic [REG_W-1:0] reg_view [NREG];
    logic [GRD_W-1:0] grd_view [NPAIR];

    logic [1:0]    rp_size [NRP];
    logic [IW-1:0] rp_idx  [NRP];
    logic [FW-1:0] rp_data [NRP];

    assign rp_size[0] = rd_size_a;
    assign rp_idx[0]  = rd_idx_a;
    assign rp_size[1] = rd_size_b;
    assign rp_idx[1]  = rd_idx_b;
    assign rd_data_a  = rp_data[0];
    assign rd_data_b  = rp_data[1];

    opf_wdec #(.REG_W(REG_W), .NREG(NREG), .GRD_W(GRD_W)) u_wdec (
        .wr_en   (wr_en),
        .wr_size (wr_size),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .reg_we  (reg_we),
        .reg_wd  (reg_wd),
        .grd_we  (grd_we),
        .grd_wd  (grd_wd)
    );

    opf_store #(.REG_W(REG_W), .NREG(NREG), .GRD_W(GRD_W)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_we   (reg_we),
        .reg_wd   (reg_wd),
        .grd_we   (grd_we),
        .grd_wd   (grd_wd),
        .reg_view (reg_view),
        .grd_view (grd_view)
    );

    for (genvar k = 0; k < NRP; k++) begin : g_rp
        opf_rport #(.REG_W(REG_W), .NREG(NREG), .GRD_W(GRD_W)) u_rport (
            .rd_size  (rp_size[k]),
            .rd_idx   (rp_idx[k]),
            .reg_view (reg_view),
            .grd_view (grd_view),
            .rd_data  (rp_data[k])
        );
    end

endmodule

// File: rtl/opf_chk.sv
module opf_chk #(
    parameter int REG_W = 16,
    parameter int NREG  = 16,
    parameter int GRD_W = 8,
    localparam int IW = $clog2(NREG),
    localparam int FW = 2 * REG_W + GRD_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_size,
    input logic [IW-1:0] wr_idx,
    input logic [FW-1:0] wr_data,
    input logic [1:0]    rd_size_a,
    input logic [IW-1:0] rd_idx_a,
    input logic [FW-1:0] rd_data_a,
    input logic [1:0]    rd_size_b,
    input logic [IW-1:0] rd_idx_b,
    input logic [FW-1:0] rd_data_b
);

    assert_half_zero_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_size_a == 2'd0 || rd_size_a == 2'd3) |-> (rd_data_a[FW-1:REG_W] == '0));

    assert_pair_no_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_size_b == 2'd1) |-> (rd_data_b[FW-1:2*REG_W] == '0));

    assert_half_bypass_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'd0 && rd_size_a == 2'd0 && rd_idx_a == wr_idx)
        |-> (rd_data_a[REG_W-1:0] == wr_data[REG_W-1:0]));

    assert_wide_bypass_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'd2 && rd_size_a == 2'd2 && rd_idx_a[IW-1:1] == wr_idx[IW-1:1])
        |-> (rd_data_a == wr_data));

    assert_pair_guard_sign_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_size == 2'd1 && rd_size_b == 2'd2 && rd_idx_b[IW-1:1] == wr_idx[IW-1:1])
        |-> (rd_data_b[FW-1:2*REG_W] == {GRD_W{wr_data[2*REG_W-1]}}));

    assert_idle_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (wr_en || !$stable(rd_size_a) || !$stable(rd_idx_a) || $stable(rd_data_a)));

endmodule

bind opf_regfile opf_chk #(.REG_W(REG_W), .NREG(NREG), .GRD_W(GRD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_size   (wr_size),
    .wr_idx    (wr_idx),
    .wr_data   (wr_data),
    .rd_size_a (rd_size_a),
    .rd_idx_a  (rd_idx_a),
    .rd_data_a (rd_data_a),
    .rd_size_b (rd_size_b),
    .rd_idx_b  (rd_idx_b),
    .rd_data_b (rd_data_b)
);

// File: tb/tb_opf_regfile.sv
`timescale 1ns/1ps
module tb_opf_regfile;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_size = '0;
    logic [3:0]  wr_idx = '0;
    logic [39:0] wr_data = '0;
    logic [1:0]  rd_size_a = '0;
    logic [3:0]  rd_idx_a = '0;
    logic [39:0] rd_data_a;
    logic [1:0]  rd_size_b = '0;
    logic [3:0]  rd_idx_b = '0;
    logic [39:0] rd_data_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    opf_regfile dut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_size(wr_size), .wr_idx(wr_idx), .wr_data(wr_data),
        .rd_size_a(rd_size_a), .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_size_b(rd_size_b), .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b)
    );

    typedef struct packed {
        logic        we;
        logic [1:0]  ws;
        logic [3:0]  wi;
        logic [39:0] wd;
        logic [1:0]  sa;
        logic [3:0]  ia;
        logic [39:0] ea;
        logic [1:0]  sb;
        logic [3:0]  ib;
        logic [39:0] eb;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 2'd0, 4'd0,  40'h00_0000_0000, 2'd2, 4'd0,  40'h00_0000_0000, 2'd0, 4'd15, 40'h00_0000_0000},
        '{1'b1, 2'd1, 4'd2,  40'h00_8765_4321, 2'd2, 4'd2,  40'hFF_8765_4321, 2'd0, 4'd3,  40'h00_0000_8765},
        '{1'b1, 2'd0, 4'd2,  40'h12_3456_AAAA, 2'd2, 4'd3,  40'hFF_8765_AAAA, 2'd1, 4'd2,  40'h00_8765_AAAA},
        '{1'b1, 2'd2, 4'd5,  40'h3C_1234_5678, 2'd2, 4'd4,  40'h3C_1234_5678, 2'd0, 4'd2,  40'h00_0000_AAAA},
        '{1'b1, 2'd1, 4'd4,  40'h55_0000_7FFF, 2'd2, 4'd4,  40'h00_0000_7FFF, 2'd2, 4'd2,  40'hFF_8765_AAAA},
        '{1'b1, 2'd0, 4'd5,  40'h00_0000_BEEF, 2'd2, 4'd4,  40'h00_BEEF_7FFF, 2'd1, 4'd5,  40'h00_BEEF_7FFF},
        '{1'b0, 2'd2, 4'd0,  40'hFF_FFFF_FFFF, 2'd2, 4'd0,  40'h00_0000_0000, 2'd0, 4'd4,  40'h00_0000_7FFF},
        '{1'b1, 2'd2, 4'd14, 40'h80_0001_0002, 2'd0, 4'd15, 40'h00_0000_0001, 2'd2, 4'd15, 40'h80_0001_0002},
        '{1'b1, 2'd3, 4'd0,  40'h99_1111_2222, 2'd2, 4'd0,  40'h00_0000_2222, 2'd2, 4'd14, 40'h80_0001_0002},
        '{1'b0, 2'd0, 4'd0,  40'h00_0000_0000, 2'd3, 4'd0,  40'h00_0000_2222, 2'd2, 4'd2,  40'hFF_8765_AAAA}
    };

    function automatic string vec_tag(int n);
        case (n)
            0: return "R1/R10 reset contents";
            1: return "R3/R7 pair write sign guard, bypass";
            2: return "R2/R5/R7 half write keeps guard, odd index pair";
            3: return "R4/R5 guarded write via odd index";
            4: return "R3 pair write clears guard, top byte ignored";
            5: return "R2/R6 half write into pair, guard kept";
            6: return "R8 disabled write no bypass";
            7: return "R4/R6 guarded write top pair";
            8: return "R9 reserved size acts as half";
            default: return "R6/R10 reserved read size, stored values";
        endcase
    endfunction

    task automatic chk(input string tag, input string port, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s port %s: actual %h expected %h", tag, port, act, exp);
        end
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : stim
        rd_size_a = 2'd2; rd_idx_a = 4'd6;
        rd_size_b = 2'd1; rd_idx_b = 4'd9;
        #2;
        chk("R1 during reset", "A", rd_data_a, 40'h0);
        chk("R1 during reset", "B", rd_data_b, 40'h0);
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            wr_en = VECS[v].we; wr_size = VECS[v].ws; wr_idx = VECS[v].wi; wr_data = VECS[v].wd;
            rd_size_a = VECS[v].sa; rd_idx_a = VECS[v].ia;
            rd_size_b = VECS[v].sb; rd_idx_b = VECS[v].ib;
            #2;
            chk(vec_tag(v), "A", rd_data_a, VECS[v].ea);
            chk(vec_tag(v), "B", rd_data_b, VECS[v].eb);
        end

        // R9: reserved size write to r0 must not touch r1 (its pair neighbour)
        @(negedge clk);
        wr_en = 1'b0;
        rd_size_a = 2'd0; rd_idx_a = 4'd1;
        rd_size_b = 2'd1; rd_idx_b = 4'd1;
        #2;
        chk("R9 neighbour untouched", "A", rd_data_a, 40'h0);
        chk("R5 odd index pair read", "B", rd_data_b, 40'h00_0000_2222);

        // R1: asynchronous clear mid-run
        @(negedge clk);
        rst_n = 1'b0;
        rd_size_a = 2'd2; rd_idx_a = 4'd14;
        rd_size_b = 2'd2; rd_idx_b = 4'd2;
        #1;
        chk("R1 clear mid-run", "A", rd_data_a, 40'h0);
        chk("R1 clear mid-run", "B", rd_data_b, 40'h0);
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        chk("R1 contents after release", "A", rd_data_a, 40'h0);
        chk("R1 contents after release", "B", rd_data_b, 40'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule